// File: doc/BRIEF.md
# Banked Exception Vector Base Bank

This block stores the exception vector base addresses for a processor core that runs in either a Secure or a Nonsecure security state. It has three base registers: a general vector base with one Secure copy and one Nonsecure copy, and a separate Monitor base that only Secure privileged code may touch. A system-register port reads or writes one of them. The register is chosen by a select bit and by the caller's security state. The caller's privilege and security state decide whether the access is legal. An illegal access raises an undefined-instruction flag.

Alongside the register port, a combinational path turns an exception kind, three routing enables and the current security state into a branch target. The target is either the Monitor base or the banked copy for the current state, plus a fixed per-exception offset. The block has no state machine; its only state is the three base registers. Each register leaves reset at zero and changes only on a permitted write.

Top module: `vbar_bank`

## Requirements
- R1: After reset all three base registers hold zero, so every legal read returns 0 and every exception target equals its bare offset.
- R2: Bits [4:0] of every base register read as zero, and bits [4:0] of the write data are ignored.
- R3: The Monitor base (`acc_sel`=1) can be read or written only when `acc_secure`=1 and `acc_priv`=1. Any other access to it sets `acc_undef` and leaves the register unchanged.
- R4: The general vector base (`acc_sel`=0) is banked. An access with `acc_secure`=1 uses the Secure copy, and one with `acc_secure`=0 uses the Nonsecure copy.
- R5: Any access with `acc_priv`=0 sets `acc_undef` and changes no register, in either security state and for either select value.
- R6: `acc_rdata` is zero whenever `acc_valid`=0 or `acc_undef`=1.
- R7: Exception codes on `exc_kind` are 0 reset, 1 undefined, 2 supervisor call, 3 secure monitor call, 4 prefetch abort, 5 data abort, 6 external abort, 7 IRQ and 8 FIQ. Their offsets are 0x00, 0x04, 0x08, 0x08, 0x0C, 0x10, 0x10, 0x18 and 0x1C. Codes 9 to 15 use offset 0x00 and are never sent to Monitor.
- R8: Code 3 always goes to Monitor. IRQ goes to Monitor only when `route_irq`=1, FIQ only when `route_fiq`=1 and external abort only when `route_ext`=1. A Monitor target is the Monitor base plus the offset, and `exc_to_mon` is 1.
- R9: Any exception not sent to Monitor uses the Secure copy when `cur_secure`=1 and the Nonsecure copy otherwise, and `exc_to_mon` is 0.
- R10: A permitted write is visible from the next clock edge. `acc_rdata` and `acc_undef` follow the request combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = general vector base, 1 = Monitor base |
| acc_secure | input | 1 | Security state of the accessing code |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_undef | output | 1 | Access raises undefined-instruction |
| exc_kind | input | 4 | Exception code |
| cur_secure | input | 1 | Current security state for target selection |
| route_irq | input | 1 | Send IRQ to Monitor |
| route_fiq | input | 1 | Send FIQ to Monitor |
| route_ext | input | 1 | Send external abort to Monitor |
| exc_target | output | 32 | Exception branch address |
| exc_to_mon | output | 1 | Target formed from the Monitor base |

## Verification
A wrong register value shows up on the first legal read of that register. It also shows up on `exc_target`, in the same cycle, for any exception that selects it. That makes a stray write, such as a user-mode or Nonsecure write reaching the Monitor base, visible one edge after the faulty access. Wrong bank steering makes the Secure and Nonsecure copies swap or merge. Loading the two copies with distinct values and checking them after every access exposes this at once. Routing faults appear as the wrong base on IRQ, FIQ or external-abort targets for the affected enable setting.

// File: rtl/vbar_pkg.sv
package vbar_pkg;

    localparam int ADDR_W    = 32;
    localparam int ALIGN_W   = 5;
    localparam int NUM_BANKS = 3;
    localparam int BANK_IW   = $clog2(NUM_BANKS);

    typedef enum logic [3:0] {
        EXC_RESET  = 4'd0,
        EXC_UNDEF  = 4'd1,
        EXC_SVC    = 4'd2,
        EXC_SMC    = 4'd3,
        EXC_PABT   = 4'd4,
        EXC_DABT   = 4'd5,
        EXC_EXTABT = 4'd6,
        EXC_IRQ    = 4'd7,
        EXC_FIQ    = 4'd8
    } exc_kind_e;

    typedef enum logic [BANK_IW-1:0] {
        BANK_NS  = 2'd0,
        BANK_S   = 2'd1,
        BANK_MON = 2'd2
    } bank_e;

endpackage

// File: rtl/vbar_access_ctrl.sv
module vbar_access_ctrl
    import vbar_pkg::*;
(
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_sel,
    input  logic                 acc_secure,
    input  logic                 acc_priv,
    output logic                 undef,
    output logic                 rd_en,
    output bank_e                rd_bank,
    output logic [NUM_BANKS-1:0] wr_en
);

    logic permitted;

    always_comb begin
        permitted = acc_priv && (!acc_sel || acc_secure);
        undef     = acc_valid && !permitted;
        rd_en     = acc_valid && permitted && !acc_write;
        if (acc_sel)
            rd_bank = BANK_MON;
        else if (acc_secure)
            rd_bank = BANK_S;
        else
            rd_bank = BANK_NS;
        wr_en = '0;
        if (acc_valid && permitted && acc_write)
            wr_en[rd_bank] = 1'b1;
    end

endmodule

// File: rtl/vbar_base_reg.sv
module vbar_base_reg #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-ALIGN_W-1:0] wdata_hi,
    output logic [ADDR_W-1:0]         base_q
);

    localparam int HI_W = ADDR_W - ALIGN_W;

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= '0;
        else if (wr_en)
            hi_q <= wdata_hi;
    end

    assign base_q = {hi_q, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/vbar_target_calc.sv
module vbar_target_calc
    import vbar_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5
) (
    input  logic [3:0]        exc_kind,
    input  logic              cur_secure,
    input  logic              route_irq,
    input  logic              route_fiq,
    input  logic              route_ext,
    input  logic [ADDR_W-1:0] base_ns,
    input  logic [ADDR_W-1:0] base_s,
    input  logic [ADDR_W-1:0] base_mon,
    output logic [ADDR_W-1:0] target,
    output logic              to_mon
);

    exc_kind_e           kind;
    logic [ALIGN_W-1:0]  offset;
    logic [ADDR_W-1:0]   base_sel;

    assign kind = exc_kind_e'(exc_kind);

    always_comb begin
        offset = '0;
        to_mon = 1'b0;
        unique case (kind)
            EXC_RESET:  offset = ALIGN_W'(5'h00);
            EXC_UNDEF:  offset = ALIGN_W'(5'h04);
            EXC_SVC:    offset = ALIGN_W'(5'h08);
            EXC_SMC: begin
                offset = ALIGN_W'(5'h08);
                to_mon = 1'b1;
            end
            EXC_PABT:   offset = ALIGN_W'(5'h0C);
            EXC_DABT:   offset = ALIGN_W'(5'h10);
            EXC_EXTABT: begin
                offset = ALIGN_W'(5'h10);
                to_mon = route_ext;
            end
            EXC_IRQ: begin
                offset = ALIGN_W'(5'h18);
                to_mon = route_irq;
            end
            EXC_FIQ: begin
                offset = ALIGN_W'(5'h1C);
                to_mon = route_fiq;
            end
            default: begin
                offset = '0;
                to_mon = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (to_mon)
            base_sel = base_mon;
        else if (cur_secure)
            base_sel = base_s;
        else
            base_sel = base_ns;
        target = base_sel + {{(ADDR_W-ALIGN_W){1'b0}}, offset};
    end

endmodule

// File: rtl/vbar_bank.sv
module vbar_bank
    import vbar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_sel,
    input  logic        acc_secure,
    input  logic        acc_priv,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_undef,
    input  logic [3:0]  exc_kind,
    input  logic        cur_secure,
    input  logic        route_irq,
    input  logic        route_fiq,
    input  logic        route_ext,
    output logic [31:0] exc_target,
    output logic        exc_to_mon
);

    logic [NUM_BANKS-1:0] wr_en;
    logic                 rd_en;
    bank_e                rd_bank;
    logic [ADDR_W-1:0]    bank_q [NUM_BANKS];
    logic [ADDR_W-1:0]    base_ns_q, base_s_q, base_mon_q;
    logic                 unused_low;

    assign unused_low = ^acc_wdata[ALIGN_W-1:0];

    vbar_access_ctrl i_ctrl (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_sel    (acc_sel),
        .acc_secure (acc_secure),
        .acc_priv   (acc_priv),
        .undef      (acc_undef),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .wr_en      (wr_en)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        vbar_base_reg #(
            .ADDR_W  (ADDR_W),
            .ALIGN_W (ALIGN_W)
        ) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wdata_hi (acc_wdata[ADDR_W-1:ALIGN_W]),
            .base_q   (bank_q[g])
        );
    end

    assign base_ns_q  = bank_q[BANK_NS];
    assign base_s_q   = bank_q[BANK_S];
    assign base_mon_q = bank_q[BANK_MON];

    assign acc_rdata = rd_en ? bank_q[rd_bank] : '0;

    vbar_target_calc #(
        .ADDR_W  (ADDR_W),
        .ALIGN_W (ALIGN_W)
    ) i_target (
        .exc_kind   (exc_kind),
        .cur_secure (cur_secure),
        .route_irq  (route_irq),
        .route_fiq  (route_fiq),
        .route_ext  (route_ext),
        .base_ns    (base_ns_q),
        .base_s     (base_s_q),
        .base_mon   (base_mon_q),
        .target     (exc_target),
        .to_mon     (exc_to_mon)
    );

endmodule

// File: rtl/vbar_bank_chk.sv
module vbar_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_sel,
    input logic        acc_secure,
    input logic        acc_priv,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        acc_undef,
    input logic [3:0]  exc_kind,
    input logic        route_irq,
    input logic        route_fiq,
    input logic        route_ext,
    input logic [31:0] exc_target,
    input logic        exc_to_mon,
    input logic [31:0] mon_q,
    input logic [31:0] sec_q,
    input logic [31:0] nsec_q
);

    p_user_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_priv |-> acc_undef);

    p_mon_nonsec_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_sel && !acc_secure |-> acc_undef);

    p_mon_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_undef |=> $stable(mon_q) && $stable(sec_q) && $stable(nsec_q));

    p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_undef) |-> acc_rdata == 32'h0);

    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[4:0] == 5'h0);

    p_smc_mon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind == 4'd3 |-> exc_to_mon && exc_target == mon_q + 32'h8);

    p_irq_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind == 4'd7 && !route_irq |-> !exc_to_mon);

    p_routed_mon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 4'd8 && route_fiq) || (exc_kind == 4'd6 && route_ext) |-> exc_to_mon);

    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_sel && !acc_undef |=> mon_q == {$past(acc_wdata[31:5]), 5'h0});

endmodule

bind vbar_bank vbar_bank_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_sel    (acc_sel),
    .acc_secure (acc_secure),
    .acc_priv   (acc_priv),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .acc_undef  (acc_undef),
    .exc_kind   (exc_kind),
    .route_irq  (route_irq),
    .route_fiq  (route_fiq),
    .route_ext  (route_ext),
    .exc_target (exc_target),
    .exc_to_mon (exc_to_mon),
    .mon_q      (base_mon_q),
    .sec_q      (base_s_q),
    .nsec_q     (base_ns_q)
);

// File: tb/test_vbar_bank.sv
module test_vbar_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0;
    logic        acc_secure = 1'b0, acc_priv = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_undef;
    logic [3:0]  exc_kind = '0;
    logic        cur_secure = 1'b0, route_irq = 1'b0, route_fiq = 1'b0, route_ext = 1'b0;
    logic [31:0] exc_target;
    logic        exc_to_mon;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_mon = '0, m_s = '0, m_ns = '0;

    always #2 clk = ~clk;

    vbar_bank i_vbar_bank (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_secure(acc_secure), .acc_priv(acc_priv), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_undef(acc_undef),
        .exc_kind(exc_kind), .cur_secure(cur_secure),
        .route_irq(route_irq), .route_fiq(route_fiq), .route_ext(route_ext),
        .exc_target(exc_target), .exc_to_mon(exc_to_mon)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample 1 ns later, commit at posedge.
    task automatic access(input logic wr, input logic sel, input logic sec,
                          input logic prv, input logic [31:0] wd,
                          output logic [31:0] rd, output logic ud);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel;
        acc_secure = sec; acc_priv = prv; acc_wdata = wd;
        #1;
        rd = acc_rdata; ud = acc_undef;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic read_all(input string tag);
        logic [31:0] rd;
        logic        ud;
        access(1'b0, 1'b1, 1'b1, 1'b1, 32'h0, rd, ud);
        check({tag, " R3 monitor readback"}, rd, m_mon);
        access(1'b0, 1'b0, 1'b1, 1'b1, 32'h0, rd, ud);
        check({tag, " R4 secure copy readback"}, rd, m_s);
        access(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, rd, ud);
        check({tag, " R4 nonsecure copy readback"}, rd, m_ns);
    endtask

    function automatic logic [31:0] exp_off(input int k);
        case (k)
            1: return 32'h04;
            2, 3: return 32'h08;
            4: return 32'h0C;
            5, 6: return 32'h10;
            7: return 32'h18;
            8: return 32'h1C;
            default: return 32'h00;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        ud;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_all("reset R1");
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            exc_kind = 4'(k); cur_secure = k[0];
            route_irq = 1'b1; route_fiq = 1'b1; route_ext = 1'b1;
            #1;
            check("R1 reset target equals offset", exc_target, exp_off(k));
        end

        // R6: idle port returns zero
        @(negedge clk);
        acc_valid = 1'b0; acc_sel = 1'b1; acc_secure = 1'b1; acc_priv = 1'b1;
        #1;
        check("R6 idle rdata", acc_rdata, 32'h0);
        check("R6 idle undef", {31'h0, acc_undef}, 32'h0);

        // Exhaustive access sweep over write/sel/sec/priv, two data patterns
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic wr, sel, sec, prv, legal;
                logic [31:0] wd, exp_rd;
                wr = c[3]; sel = c[2]; sec = c[1]; prv = c[0];
                wd = (p == 0) ? (32'hA5C3_0F1F + 32'(c) * 32'h0101_0040)
                              : (32'h5A3C_F0E7 ^ (32'(c) << 8));
                legal = prv && (!sel || sec);
                exp_rd = 32'h0;
                if (legal && !wr)
                    exp_rd = sel ? m_mon : (sec ? m_s : m_ns);
                access(wr, sel, sec, prv, wd, rd, ud);
                check(prv ? "R3 undef flag" : "R5 undef flag", {31'h0, ud}, {31'h0, !legal});
                check("R6 R10 same-cycle rdata", rd, exp_rd);
                if (legal && wr) begin
                    if (sel) m_mon = wd & 32'hFFFF_FFE0;
                    else if (sec) m_s = wd & 32'hFFFF_FFE0;
                    else m_ns = wd & 32'hFFFF_FFE0;
                end
                read_all("R2 R3 R5 R10 after access");
            end
        end

        // Distinct bases for the routing sweep
        access(1'b1, 1'b1, 1'b1, 1'b1, 32'h7000_001F, rd, ud); m_mon = 32'h7000_0000;
        access(1'b1, 1'b0, 1'b1, 1'b1, 32'h3000_0060, rd, ud); m_s   = 32'h3000_0060;
        access(1'b1, 1'b0, 1'b0, 1'b1, 32'h1000_0FA0, rd, ud); m_ns  = 32'h1000_0FA0;
        read_all("R2 setup");

        // Exhaustive exception sweep: 16 codes x state x 8 routing settings
        for (int k = 0; k < 16; k++) begin
            for (int r = 0; r < 16; r++) begin
                logic mon;
                @(negedge clk);
                exc_kind = 4'(k); cur_secure = r[3];
                route_irq = r[0]; route_fiq = r[1]; route_ext = r[2];
                mon = (k == 3) || (k == 7 && r[0]) || (k == 8 && r[1]) || (k == 6 && r[2]);
                #1;
                check(mon ? "R8 monitor flag" : "R9 monitor flag",
                      {31'h0, exc_to_mon}, {31'h0, mon});
                check(mon ? "R7 R8 target" : "R7 R9 target", exc_target,
                      (mon ? m_mon : (r[3] ? m_s : m_ns)) + exp_off(k));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule